// File: doc/BRIEF.md
# USB Host Port Bus State Sequencer

This block controls the bus-level condition of one USB host port. It turns the port power request on and off and watches the sampled D+ and D- levels to report when a device appears or goes away. It drives the line commands for a bus reset and for a resume. It also keeps the start-of-frame enable flag. While that flag is low the bus is treated as suspended.

Software-style control strobes arrive as one-cycle pulses. The block answers with sticky interrupt flags, a line command for the transceiver, and a one-cycle pulse that tells the pipe logic to release every pipe. The pipe logic acts on that pulse when a bus reset finishes.

A reset requested while the bus is suspended does more than a plain reset. When the reset drive ends, a resume drive follows. After the resume the wake-up flag is raised and frame generation is switched on, so frames start as soon as the sequence ends.

Top module: `usb_host_bus_ctrl`

## Requirements
- R1: After reset every output is low: `vbusReq`, `sofEn`, `resetBusy`, `deallocAll`, `devAttached`, and all of `irqFlags`. `lineCmd` is 0, which means normal.
- R2: A pulse on `vbusReqSet` sets `vbusReq` on the next edge and a pulse on `vbusReqClr` clears it. When both pulse in the same cycle, `vbusReq` ends up set.
- R3: D+ and D- pass through two synchroniser flops. An attach is reported only while `vbusReq` is 1, `devAttached` is 0, and at least one line is high for DEBOUNCE_CYCLES consecutive synchronised samples. `devAttached` and the connect flag (`irqFlags[2]`) then rise together, 2+DEBOUNCE_CYCLES edges after the line goes high.
- R4: While `devAttached` is 1, both lines low for DEBOUNCE_CYCLES consecutive synchronised samples clears `devAttached` and sets the disconnect flag (`irqFlags[3]`). This happens 2+DEBOUNCE_CYCLES edges after the lines go low.
- R5: A `sendReset` pulse while the sequencer is idle drives `lineCmd` to 1 (reset) and raises `resetBusy` for exactly RESET_CYCLES cycles. A `sendReset` pulse while a sequence is running is ignored.
- R6: On the edge that ends the reset drive, three things happen together: `resetBusy` returns to 0, the reset-sent flag (`irqFlags[0]`) is set, and `deallocAll` goes high for exactly one cycle.
- R7: If `sofEn` was 0 when the reset was accepted, `lineCmd` is 2 (resume) for RESUME_CYCLES cycles after the reset drive. At the end of the resume, the wake-up flag (`irqFlags[1]`) and `sofEn` are both set.
- R8: If `sofEn` was 1 when the reset was accepted, no resume follows. `lineCmd` returns to 0 right after the reset drive, `sofEn` stays 1 and the wake-up flag is not set.
- R9: `sofEnSet` sets `sofEn` and `sofEnClr` clears it. When both pulse in the same cycle, `sofEn` ends up set. The bus counts as suspended whenever `sofEn` is 0.
- R10: Each bit of `flagClr` clears the matching bit of `irqFlags`. A set event and a clear in the same cycle leave the flag set.
- R11: Attach and detach detection is frozen while `lineCmd` is not 0. Line levels seen during a reset or resume drive do not change `devAttached`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| vbusReqSet | input | 1 | Strobe: request port power |
| vbusReqClr | input | 1 | Strobe: withdraw port power request |
| sendReset | input | 1 | Strobe: start a bus reset |
| sofEnSet | input | 1 | Strobe: enable frame generation |
| sofEnClr | input | 1 | Strobe: disable frame generation (suspend) |
| flagClr | input | 4 | Per-flag clear strobes, same bit order as irqFlags |
| dpLine | input | 1 | Raw D+ level |
| dmLine | input | 1 | Raw D- level |
| vbusReq | output | 1 | Port power request |
| lineCmd | output | 2 | Line command: 0 normal, 1 drive reset, 2 drive resume |
| sofEn | output | 1 | Frame generation enabled |
| resetBusy | output | 1 | Reset bit; high during the reset drive, clears itself at the end |
| irqFlags | output | 4 | Sticky flags: 0 reset sent, 1 wake-up, 2 connect, 3 disconnect |
| deallocAll | output | 1 | One-cycle pulse: release all pipes |
| devAttached | output | 1 | A device is present on the port |

## Verification
Some rules can be checked from one edge to the next, so the embedded assertions cover them on every cycle:
- the pipe-release pulse lasts one cycle and comes with the end of the reset drive;
- a connect never appears without port power;
- the wake-up flag always comes with frame generation enabled;
- attachment does not change while a line command is active;
- a set event always wins over a same-cycle clear;
- a reset request during a resume is ignored.

Other behaviour only shows up in the bench scenarios. These include the exact lengths of the reset and resume drives, the debounce latency, and the choice between the suspended and running reset paths. They also include the order of events that the scoreboard compares.

// File: rtl/usbh_bus_pkg.sv
package usbh_bus_pkg;

  typedef enum logic [1:0] {
    LINE_NORMAL = 2'd0,
    LINE_RESET  = 2'd1,
    LINE_RESUME = 2'd2
  } line_cmd_e;

  localparam int FLAG_RST_SENT = 0;
  localparam int FLAG_WAKE     = 1;
  localparam int FLAG_CONN     = 2;
  localparam int FLAG_DISC     = 3;
  localparam int NUM_FLAGS     = 4;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic rstDone;     // last cycle of the reset drive
    logic resumeDone;  // last cycle of the resume drive
    logic lineFrozen;  // a line command is active
  } bus_strobes_t;

endpackage

// File: rtl/usbh_bus_control.sv
module usbh_bus_control
  import usbh_bus_pkg::*;
#(
  parameter int RESET_CYCLES  = 3000000,
  parameter int RESUME_CYCLES = 1200000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sendReset,
  input  logic         sofEn,
  output line_cmd_e    lineCmd,
  output logic         resetBusy,
  output bus_strobes_t strb
);

  localparam int MAX_CYCLES = (RESET_CYCLES > RESUME_CYCLES) ? RESET_CYCLES : RESUME_CYCLES;
  localparam int CW = (MAX_CYCLES > 1) ? $clog2(MAX_CYCLES) : 1;
  localparam logic [CW-1:0] RST_LAST = CW'(RESET_CYCLES - 1);
  localparam logic [CW-1:0] RES_LAST = CW'(RESUME_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_RESET, S_RESUME} seq_state_e;

  seq_state_e  state;
  logic [CW-1:0] cnt;
  logic        needResume;
  logic        rstLast;
  logic        resLast;

  assign rstLast = (state == S_RESET)  && (cnt == RST_LAST);
  assign resLast = (state == S_RESUME) && (cnt == RES_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      cnt        <= '0;
      needResume <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (sendReset) begin
            state      <= S_RESET;
            needResume <= !sofEn;
          end
        end
        S_RESET: begin
          if (rstLast) begin
            cnt   <= '0;
            state <= needResume ? S_RESUME : S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RESUME: begin
          if (resLast) begin
            cnt        <= '0;
            state      <= S_IDLE;
            needResume <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state)
      S_RESET:  lineCmd = LINE_RESET;
      S_RESUME: lineCmd = LINE_RESUME;
      default:  lineCmd = LINE_NORMAL;
    endcase
  end

  assign resetBusy       = (state == S_RESET);
  assign strb.rstDone    = rstLast;
  assign strb.resumeDone = resLast;
  assign strb.lineFrozen = (state != S_IDLE);

  // R5: the reset drive ends only after its full length
  assert_reset_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetBusy) |-> ($past(cnt) == RST_LAST));

  // R5: a reset request during a resume does not restart the reset
  assert_ignore_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RESUME && sendReset) |=> (state != S_RESET));

endmodule

// File: rtl/usbh_bus_datapath.sv
module usbh_bus_datapath
  import usbh_bus_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 1000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 vbusReqSet,
  input  logic                 vbusReqClr,
  input  logic                 sofEnSet,
  input  logic                 sofEnClr,
  input  logic [NUM_FLAGS-1:0] flagClr,
  input  logic                 dpLine,
  input  logic                 dmLine,
  input  bus_strobes_t         strb,
  output logic                 vbusReq,
  output logic                 sofEn,
  output logic [NUM_FLAGS-1:0] irqFlags,
  output logic                 deallocAll,
  output logic                 devAttached
);

  localparam int DW = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [DW-1:0] DB_LAST = DW'(DEBOUNCE_CYCLES - 1);
  localparam int SYNC_STAGES = 2;

  // Two-flop synchroniser for both lines
  logic [1:0] syncPipe [SYNC_STAGES];
  logic [1:0] lineSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= 2'b00;
    end else begin
      syncPipe[0] <= {dpLine, dmLine};
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign lineSync = syncPipe[SYNC_STAGES-1];

  // Debounced attach / detach detection
  logic          anyHigh;
  logic          wantAttach;
  logic          wantDetach;
  logic          attachEv;
  logic          detachEv;
  logic [DW-1:0] dbCnt;

  assign anyHigh    = |lineSync;
  assign wantAttach = !strb.lineFrozen && !devAttached && vbusReq && anyHigh;
  assign wantDetach = !strb.lineFrozen && devAttached && !anyHigh;
  assign attachEv   = wantAttach && (dbCnt == DB_LAST);
  assign detachEv   = wantDetach && (dbCnt == DB_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbCnt       <= '0;
      devAttached <= 1'b0;
    end else begin
      if (!(wantAttach || wantDetach) || attachEv || detachEv) dbCnt <= '0;
      else                                                    dbCnt <= dbCnt + 1'b1;
      if (attachEv)      devAttached <= 1'b1;
      else if (detachEv) devAttached <= 1'b0;
    end
  end

  // Power request and frame enable: set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vbusReq    <= 1'b0;
      sofEn      <= 1'b0;
      deallocAll <= 1'b0;
    end else begin
      if (vbusReqSet)      vbusReq <= 1'b1;
      else if (vbusReqClr) vbusReq <= 1'b0;
      if (sofEnSet || strb.resumeDone) sofEn <= 1'b1;
      else if (sofEnClr)               sofEn <= 1'b0;
      deallocAll <= strb.rstDone;
    end
  end

  // Sticky interrupt flags
  logic [NUM_FLAGS-1:0] setVec;

  always_comb begin
    setVec                = '0;
    setVec[FLAG_RST_SENT] = strb.rstDone;
    setVec[FLAG_WAKE]     = strb.resumeDone;
    setVec[FLAG_CONN]     = attachEv;
    setVec[FLAG_DISC]     = detachEv;
  end

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           irqFlags[f] <= 1'b0;
      else if (setVec[f])  irqFlags[f] <= 1'b1;
      else if (flagClr[f]) irqFlags[f] <= 1'b0;
    end

    // R10: a set event always lands, whatever the clear strobe does
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
      setVec[f] |=> irqFlags[f]);
  end

  // R6: the pipe release pulse lasts a single cycle
  assert_dealloc_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    deallocAll |=> !deallocAll);

  // R3: a connect is reported only with port power requested
  assert_conn_needs_vbus_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlags[FLAG_CONN]) |-> $past(vbusReq));

  // R7: the wake-up flag arrives together with frame generation
  assert_wake_sof_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlags[FLAG_WAKE]) |-> sofEn);

  // R11: attachment holds while a line command is active
  assert_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.lineFrozen |=> $stable(devAttached));

endmodule

// File: rtl/usb_host_bus_ctrl.sv
module usb_host_bus_ctrl
  import usbh_bus_pkg::*;
#(
  parameter int DEBOUNCE_CYCLES = 1000,
  parameter int RESET_CYCLES    = 3000000,
  parameter int RESUME_CYCLES   = 1200000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vbusReqSet,
  input  logic       vbusReqClr,
  input  logic       sendReset,
  input  logic       sofEnSet,
  input  logic       sofEnClr,
  input  logic [3:0] flagClr,
  input  logic       dpLine,
  input  logic       dmLine,
  output logic       vbusReq,
  output logic [1:0] lineCmd,
  output logic       sofEn,
  output logic       resetBusy,
  output logic [3:0] irqFlags,
  output logic       deallocAll,
  output logic       devAttached
);

  bus_strobes_t strb;
  line_cmd_e    lineCmdInt;

  usbh_bus_control #(
    .RESET_CYCLES (RESET_CYCLES),
    .RESUME_CYCLES(RESUME_CYCLES)
  ) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .sendReset(sendReset),
    .sofEn    (sofEn),
    .lineCmd  (lineCmdInt),
    .resetBusy(resetBusy),
    .strb     (strb)
  );

  usbh_bus_datapath #(
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .vbusReqSet (vbusReqSet),
    .vbusReqClr (vbusReqClr),
    .sofEnSet   (sofEnSet),
    .sofEnClr   (sofEnClr),
    .flagClr    (flagClr),
    .dpLine     (dpLine),
    .dmLine     (dmLine),
    .strb       (strb),
    .vbusReq    (vbusReq),
    .sofEn      (sofEn),
    .irqFlags   (irqFlags),
    .deallocAll (deallocAll),
    .devAttached(devAttached)
  );

  assign lineCmd = lineCmdInt;

  // R6: the end of the reset drive comes with the pipe release pulse
  assert_reset_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetBusy) |-> deallocAll);

endmodule

// File: tb/test_usb_host_bus_ctrl.sv
module test_usb_host_bus_ctrl;

  localparam time CLK_PERIOD = 10ns;
  localparam int  DB  = 4;
  localparam int  RST = 20;
  localparam int  RES = 10;

  localparam int EV_RST = 0, EV_WAKE = 1, EV_CONN = 2, EV_DISC = 3, EV_DEALLOC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vbusReqSet = 0, vbusReqClr = 0, sendReset = 0, sofEnSet = 0, sofEnClr = 0;
  logic [3:0] flagClr = '0;
  logic dpLine = 0, dmLine = 0;
  logic vbusReq, sofEn, resetBusy, deallocAll, devAttached;
  logic [1:0] lineCmd;
  logic [3:0] irqFlags;

  int checks = 0;
  int errors = 0;
  int expQ[$];
  logic [3:0] prevFlags = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_host_bus_ctrl #(
    .DEBOUNCE_CYCLES(DB), .RESET_CYCLES(RST), .RESUME_CYCLES(RES)
  ) i_usb_host_bus_ctrl (
    .clk(clk), .rstN(rstN), .vbusReqSet(vbusReqSet), .vbusReqClr(vbusReqClr),
    .sendReset(sendReset), .sofEnSet(sofEnSet), .sofEnClr(sofEnClr),
    .flagClr(flagClr), .dpLine(dpLine), .dmLine(dmLine), .vbusReq(vbusReq),
    .lineCmd(lineCmd), .sofEn(sofEn), .resetBusy(resetBusy), .irqFlags(irqFlags),
    .deallocAll(deallocAll), .devAttached(devAttached)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Monitor: pops expected events in order as the design produces them
  always @(negedge clk) begin
    if (rstN && !done) begin
      for (int b = 0; b < 5; b++) begin
        bit seen;
        seen = (b < 4) ? (irqFlags[b] && !prevFlags[b]) : deallocAll;
        if (seen) begin
          if (expQ.size() == 0) chk("SB", "unexpected event", b, 32'hFF);
          else chk("SB", "event order", b, expQ.pop_front());
        end
      end
      prevFlags = irqFlags;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "vbusReq", vbusReq, 0);
    chk("R1", "lineCmd", lineCmd, 0);
    chk("R1", "sofEn", sofEn, 0);
    chk("R1", "resetBusy", resetBusy, 0);
    chk("R1", "irqFlags", irqFlags, 0);
    chk("R1", "deallocAll", deallocAll, 0);
    chk("R1", "devAttached", devAttached, 0);

    // R2 power request strobes
    vbusReqSet = 1; @(negedge clk); vbusReqSet = 0;
    chk("R2", "set", vbusReq, 1);
    vbusReqSet = 1; vbusReqClr = 1; @(negedge clk); vbusReqSet = 0; vbusReqClr = 0;
    chk("R2", "set wins", vbusReq, 1);
    vbusReqClr = 1; @(negedge clk); vbusReqClr = 0;
    chk("R2", "clear", vbusReq, 0);

    // R3 no attach without power
    dpLine = 1; repeat (20) @(negedge clk);
    chk("R3", "no power connect flag", irqFlags[2], 0);
    chk("R3", "no power attached", devAttached, 0);
    dpLine = 0; repeat (4) @(negedge clk);
    vbusReqSet = 1; @(negedge clk); vbusReqSet = 0;
    dmLine = 1; expQ.push_back(EV_CONN);
    repeat (1 + DB) @(negedge clk);
    chk("R3", "attach too early", devAttached, 0);
    @(negedge clk);
    chk("R3", "attach", devAttached, 1);
    chk("R3", "connect flag", irqFlags[2], 1);

    // R10 clear strobe
    flagClr = 4'b0100; @(negedge clk); flagClr = 0;
    chk("R10", "connect cleared", irqFlags[2], 0);

    // R5 R6 R7 R11 reset while suspended
    sendReset = 1; @(posedge clk); @(negedge clk); sendReset = 0; dmLine = 0;
    expQ.push_back(EV_RST); expQ.push_back(EV_DEALLOC); expQ.push_back(EV_WAKE);
    chk("R5", "lineCmd reset", lineCmd, 1);
    chk("R5", "resetBusy", resetBusy, 1);
    repeat (5) @(negedge clk);
    sendReset = 1; @(negedge clk); sendReset = 0;
    chk("R5", "busy ignore", lineCmd, 1);
    dmLine = 1;
    repeat (RST - 7) @(negedge clk);
    chk("R5", "reset length", lineCmd, 1);
    chk("R5", "busy at end", resetBusy, 1);
    chk("R6", "flag not yet", irqFlags[0], 0);
    @(negedge clk);
    chk("R7", "resume cmd", lineCmd, 2);
    chk("R6", "busy cleared", resetBusy, 0);
    chk("R6", "dealloc pulse", deallocAll, 1);
    chk("R6", "reset sent flag", irqFlags[0], 1);
    chk("R11", "attached frozen", devAttached, 1);
    @(negedge clk);
    chk("R6", "dealloc one cycle", deallocAll, 0);
    repeat (RES - 2) @(negedge clk);
    chk("R7", "resume length", lineCmd, 2);
    chk("R7", "sof not yet", sofEn, 0);
    chk("R7", "wake not yet", irqFlags[1], 0);
    @(negedge clk);
    chk("R7", "normal after resume", lineCmd, 0);
    chk("R7", "sof on", sofEn, 1);
    chk("R7", "wake flag", irqFlags[1], 1);
    chk("R11", "still attached", devAttached, 1);

    flagClr = 4'hF; @(negedge clk); flagClr = 0;
    chk("R10", "all cleared", irqFlags, 0);

    // R8 reset while running, R10 set wins
    sendReset = 1; @(posedge clk); @(negedge clk); sendReset = 0;
    expQ.push_back(EV_RST); expQ.push_back(EV_DEALLOC);
    chk("R8", "lineCmd reset", lineCmd, 1);
    repeat (RST - 1) @(negedge clk);
    flagClr = 4'b0001; @(negedge clk); flagClr = 0;
    chk("R10", "set wins over clear", irqFlags[0], 1);
    chk("R8", "no resume", lineCmd, 0);
    chk("R8", "sof kept", sofEn, 1);
    repeat (RES + 2) @(negedge clk);
    chk("R8", "no wake flag", irqFlags[1], 0);
    chk("R8", "still normal", lineCmd, 0);

    // R9 frame enable strobes
    sofEnClr = 1; @(negedge clk); sofEnClr = 0;
    chk("R9", "clear", sofEn, 0);
    sofEnSet = 1; sofEnClr = 1; @(negedge clk); sofEnSet = 0; sofEnClr = 0;
    chk("R9", "set wins", sofEn, 1);

    // R4 detach
    dmLine = 0; expQ.push_back(EV_DISC);
    repeat (1 + DB) @(negedge clk);
    chk("R4", "detach too early", devAttached, 1);
    @(negedge clk);
    chk("R4", "detached", devAttached, 0);
    chk("R4", "disconnect flag", irqFlags[3], 1);

    repeat (4) @(negedge clk);
    chk("SB", "queue drained", expQ.size(), 0);
    finishRun();
  end

endmodule